// File: doc/BRIEF.md
# Table-Driven Quantized Variable-Node Update Unit

This unit computes the variable-node step of a low-width message-passing LDPC decoder. Each operation takes one channel symbol and up to `MAX_DEG` check-to-variable symbols. Every symbol passes through a single-input lookup table that turns it into a signed integer. The integers are added to form an a posteriori total. For each edge, the unit subtracts that edge's own integer from the total. A second single-input table then folds the result back into a narrow outgoing symbol. The sign of the total gives a hard bit decision.

Three tables exist for every iteration: one that reconstructs channel symbols, one that reconstructs check-to-variable symbols, and one that quantizes sums. The iteration index given with each operation picks the table set. Layer and code rate have no effect on the choice. The tables are loaded through a write port that accepts data only while no operation is in flight. A node of lower degree disables its unused slots. A disabled slot adds nothing to the sum and returns symbol 0.

Top module: `vnu_lut_update`

## Requirements
- R1: While reset is held, and right after it, `out_valid` is 0 and `idle` is 1.
- R2: A `start` sampled high at a rising edge makes `out_valid` high for exactly one cycle, starting after the second rising edge that follows. Starts may arrive on consecutive cycles, and each one produces its own result.
- R3: The channel symbol is converted by the channel table of the iteration `iter`. Each check symbol is converted by the check table of that same iteration. Entries are `REC_W`-bit two's-complement integers. No other iteration's tables affect the result.
- R4: The outgoing symbol of an enabled slot is the quantization table entry of iteration `iter` at address (total − own value) mod 2^`EXT_W`. The total is the channel value plus the values of all enabled slots.
- R5: `hard_bit` is 1 when the total is negative and 0 otherwise, so a total of exactly zero gives 0.
- R6: A slot whose `slot_en` bit is 0 adds zero to the total, and its outgoing symbol is 0.
- R7: A write stores into the table chosen by `wr_sel` for iteration `wr_iter`. `wr_sel` 0 selects the channel table (address in the low `SYM_W` bits). `wr_sel` 1 selects the check table (address in the low `SYM_W` bits). `wr_sel` 2 selects the quantization table (data in the low `SYM_W` bits). `wr_sel` 3 stores nothing. Every operation started after the write sees the new entry.
- R8: A write is discarded if `start` is high in the same cycle or if `idle` is low.
- R9: `idle` is low in exactly the cycle after a cycle in which `start` was sampled.
- R10: Sums are exact across the full range of entries. For example, five values of −16 give a total of −80 and an extrinsic value of −64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an update with the inputs presented in this cycle |
| iter | input | IT_W | Iteration index that selects the table set |
| ch_sym | input | SYM_W | Channel symbol |
| c2v_sym | input | MAX_DEG*SYM_W | Check-to-variable symbols, slot g at bits g*SYM_W |
| slot_en | input | MAX_DEG | Per-slot enable, where 0 masks the slot |
| out_valid | output | 1 | Result strobe |
| v2c_sym | output | MAX_DEG*SYM_W | Outgoing symbols, slot g at bits g*SYM_W |
| hard_bit | output | 1 | Sign of the a posteriori total |
| idle | output | 1 | No operation in flight, so writes are accepted |
| wr_en | input | 1 | Table write request |
| wr_iter | input | IT_W | Iteration whose table is written |
| wr_sel | input | 2 | 0 channel, 1 check, 2 quantization, 3 none |
| wr_addr | input | EXT_W | Table address |
| wr_data | input | REC_W | Entry value |

## Verification
Outgoing symbols and the hard bit appear two cycles after the edge that samples `start`. `idle` drops for the one cycle in between. Table writes take effect at the edge that samples them. The bench keeps a reference model with a two-slot delay line that advances on each rising edge, and compares `out_valid`, `idle` and every result field on each falling edge. Checks are therefore made between edges, once every register on the path has settled. Directed cases also sample the result on the falling edge exactly two cycles after the start: the zero total, the most negative total, and writes made while busy or together with `start`.

// File: rtl/vnu_pkg.sv
// Shared encodings for the variable-node update unit.
// Assumes: nothing beyond SystemVerilog 2017 packages.
package vnu_pkg;
    // Table-select codes on the write port
    typedef enum logic [1:0] {
        TBL_CH   = 2'd0,
        TBL_CV   = 2'd1,
        TBL_Q    = 2'd2,
        TBL_NONE = 2'd3
    } tbl_sel_e;
endpackage

// File: rtl/vnu_rec_tables.sv
// Reconstruction tables: per iteration one channel table and one
// check-to-variable table, each mapping a symbol to a signed integer.
// Assumes: N_ITER is a power of two >= 2; reads are combinational.
module vnu_rec_tables #(
    parameter int SYM_W   = 3,
    parameter int REC_W   = 5,
    parameter int MAX_DEG = 4,
    parameter int N_ITER  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_ch,
    input  logic                       we_cv,
    input  logic [$clog2(N_ITER)-1:0]  wr_iter,
    input  logic [SYM_W-1:0]           wr_addr,
    input  logic [REC_W-1:0]           wr_data,
    input  logic [$clog2(N_ITER)-1:0]  rd_iter,
    input  logic [SYM_W-1:0]           ch_sym,
    input  logic [MAX_DEG*SYM_W-1:0]   cv_sym,
    output logic [REC_W-1:0]           ch_val,
    output logic [MAX_DEG*REC_W-1:0]   cv_val
);
    localparam int DEPTH = N_ITER << SYM_W;

    logic [REC_W-1:0] ch_mem [DEPTH];
    logic [REC_W-1:0] cv_mem [DEPTH];

    // Storage update: clear on reset, else accept gated writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                ch_mem[k] <= '0;
                cv_mem[k] <= '0;
            end
        end else begin
            if (we_ch) ch_mem[{wr_iter, wr_addr}] <= wr_data;
            if (we_cv) cv_mem[{wr_iter, wr_addr}] <= wr_data;
        end
    end

    assign ch_val = ch_mem[{rd_iter, ch_sym}];

    generate
        for (genvar g = 0; g < MAX_DEG; g++) begin : g_rd
            assign cv_val[g*REC_W +: REC_W] = cv_mem[{rd_iter, cv_sym[g*SYM_W +: SYM_W]}];
        end
    endgenerate
endmodule

// File: rtl/vnu_sum.sv
// Integer combiner: forms the a posteriori total and, per edge, the
// total minus that edge's own value (modulo 2^EXT_W).
// Assumes: masked slots already carry zero; SUM_W > EXT_W >= REC_W.
module vnu_sum #(
    parameter int REC_W   = 5,
    parameter int MAX_DEG = 4,
    parameter int SUM_W   = 8,
    parameter int EXT_W   = 7
) (
    input  logic [REC_W-1:0]          ch_val,
    input  logic [MAX_DEG*REC_W-1:0]  cv_val,
    output logic                      neg,
    output logic [MAX_DEG*EXT_W-1:0]  ext
);
    logic [SUM_W-1:0] total;

    // Sign-extended accumulation of channel and all edge values
    always_comb begin
        total = {{(SUM_W-REC_W){ch_val[REC_W-1]}}, ch_val};
        for (int k = 0; k < MAX_DEG; k++) begin
            total = total + {{(SUM_W-REC_W){cv_val[k*REC_W+REC_W-1]}}, cv_val[k*REC_W +: REC_W]};
        end
    end

    assign neg = total[SUM_W-1];

    generate
        for (genvar g = 0; g < MAX_DEG; g++) begin : g_ext
            assign ext[g*EXT_W +: EXT_W] = total[EXT_W-1:0]
                - {{(EXT_W-REC_W){cv_val[g*REC_W+REC_W-1]}}, cv_val[g*REC_W +: REC_W]};
        end
    endgenerate
endmodule

// File: rtl/vnu_quant_table.sv
// Quantization tables: per iteration one table that maps an extrinsic
// integer (as an EXT_W-bit address) to an outgoing symbol.
// Assumes: N_ITER is a power of two >= 2; reads are combinational.
module vnu_quant_table #(
    parameter int SYM_W   = 3,
    parameter int EXT_W   = 7,
    parameter int MAX_DEG = 4,
    parameter int N_ITER  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(N_ITER)-1:0]  wr_iter,
    input  logic [EXT_W-1:0]           wr_addr,
    input  logic [SYM_W-1:0]           wr_data,
    input  logic [$clog2(N_ITER)-1:0]  rd_iter,
    input  logic [MAX_DEG*EXT_W-1:0]   rd_addr,
    output logic [MAX_DEG*SYM_W-1:0]   rd_sym
);
    localparam int DEPTH = N_ITER << EXT_W;

    logic [SYM_W-1:0] q_mem [DEPTH];

    // Storage update: clear on reset, else accept gated writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) q_mem[k] <= '0;
        end else if (we) begin
            q_mem[{wr_iter, wr_addr}] <= wr_data;
        end
    end

    generate
        for (genvar g = 0; g < MAX_DEG; g++) begin : g_rd
            assign rd_sym[g*SYM_W +: SYM_W] = q_mem[{rd_iter, rd_addr[g*EXT_W +: EXT_W]}];
        end
    endgenerate
endmodule

// File: rtl/vnu_lut_update.sv
// Variable-node update unit: reconstruct, add, requantize.
// Stage 1 registers the reconstructed (masked) values; stage 2 registers
// the quantized extrinsic symbols and the hard bit. Latency two cycles.
// Assumes: table writes only while idle, so reads in flight never race.
module vnu_lut_update #(
    parameter int SYM_W   = 3,
    parameter int REC_W   = 5,
    parameter int MAX_DEG = 4,
    parameter int N_ITER  = 4,
    localparam int IT_W   = $clog2(N_ITER),
    localparam int EXT_W  = REC_W + $clog2(MAX_DEG),
    localparam int SUM_W  = REC_W + $clog2(MAX_DEG + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [IT_W-1:0]           iter,
    input  logic [SYM_W-1:0]          ch_sym,
    input  logic [MAX_DEG*SYM_W-1:0]  c2v_sym,
    input  logic [MAX_DEG-1:0]        slot_en,
    output logic                      out_valid,
    output logic [MAX_DEG*SYM_W-1:0]  v2c_sym,
    output logic                      hard_bit,
    output logic                      idle,
    input  logic                      wr_en,
    input  logic [IT_W-1:0]           wr_iter,
    input  logic [1:0]                wr_sel,
    input  logic [EXT_W-1:0]          wr_addr,
    input  logic [REC_W-1:0]          wr_data
);
    import vnu_pkg::*;

    logic                      s1_valid;
    logic [IT_W-1:0]           s1_iter;
    logic [REC_W-1:0]          s1_ch;
    logic [MAX_DEG*REC_W-1:0]  s1_cv;
    logic [MAX_DEG-1:0]        s1_mask;

    logic [REC_W-1:0]          ch_val;
    logic [MAX_DEG*REC_W-1:0]  cv_val;
    logic                      neg;
    logic [MAX_DEG*EXT_W-1:0]  ext;
    logic [MAX_DEG*SYM_W-1:0]  q_sym;
    logic                      wr_ok;

    assign idle  = !s1_valid;
    assign wr_ok = wr_en && !start && idle;

    vnu_rec_tables #(.SYM_W(SYM_W), .REC_W(REC_W), .MAX_DEG(MAX_DEG), .N_ITER(N_ITER)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_ch   (wr_ok && (wr_sel == TBL_CH)),
        .we_cv   (wr_ok && (wr_sel == TBL_CV)),
        .wr_iter (wr_iter),
        .wr_addr (wr_addr[SYM_W-1:0]),
        .wr_data (wr_data),
        .rd_iter (iter),
        .ch_sym  (ch_sym),
        .cv_sym  (c2v_sym),
        .ch_val  (ch_val),
        .cv_val  (cv_val)
    );

    // Stage 1: capture reconstructed values, zeroing masked slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_iter  <= '0;
            s1_ch    <= '0;
            s1_cv    <= '0;
            s1_mask  <= '0;
        end else begin
            s1_valid <= start;
            if (start) begin
                s1_iter <= iter;
                s1_ch   <= ch_val;
                s1_mask <= slot_en;
                for (int k = 0; k < MAX_DEG; k++) begin
                    s1_cv[k*REC_W +: REC_W] <= slot_en[k] ? cv_val[k*REC_W +: REC_W] : '0;
                end
            end
        end
    end

    vnu_sum #(.REC_W(REC_W), .MAX_DEG(MAX_DEG), .SUM_W(SUM_W), .EXT_W(EXT_W)) u_sum (
        .ch_val (s1_ch),
        .cv_val (s1_cv),
        .neg    (neg),
        .ext    (ext)
    );

    vnu_quant_table #(.SYM_W(SYM_W), .EXT_W(EXT_W), .MAX_DEG(MAX_DEG), .N_ITER(N_ITER)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_ok && (wr_sel == TBL_Q)),
        .wr_iter (wr_iter),
        .wr_addr (wr_addr),
        .wr_data (wr_data[SYM_W-1:0]),
        .rd_iter (s1_iter),
        .rd_addr (ext),
        .rd_sym  (q_sym)
    );

    // Stage 2: register quantized symbols, hard bit and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            v2c_sym   <= '0;
            hard_bit  <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                hard_bit <= neg;
                for (int k = 0; k < MAX_DEG; k++) begin
                    v2c_sym[k*SYM_W +: SYM_W] <= s1_mask[k] ? q_sym[k*SYM_W +: SYM_W] : '0;
                end
            end
        end
    end

    // R2
    start_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##2 out_valid);

    // R2
    valid_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(start, 2));

    // R9
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !idle);

    generate
        for (genvar g = 0; g < MAX_DEG; g++) begin : g_chk
            // R6
            masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && !$past(slot_en[g], 2)) |-> (v2c_sym[g*SYM_W +: SYM_W] == '0));
        end
    endgenerate
endmodule

// File: tb/sim_vnu_lut_update.sv
`timescale 1ns/1ps
module sim_vnu_lut_update;
    localparam int SYM_W = 3, REC_W = 5, MAX_DEG = 4, N_ITER = 4;
    localparam int IT_W = 2, EXT_W = 7;
    localparam int NSYM = 1 << SYM_W, NQ = 1 << EXT_W;

    logic clk = 0, rst_n = 0;
    logic start = 0;
    logic [IT_W-1:0] iter = 0;
    logic [SYM_W-1:0] ch_sym = 0;
    logic [MAX_DEG*SYM_W-1:0] c2v_sym = 0;
    logic [MAX_DEG-1:0] slot_en = 0;
    logic out_valid, hard_bit, idle;
    logic [MAX_DEG*SYM_W-1:0] v2c_sym;
    logic wr_en = 0;
    logic [IT_W-1:0] wr_iter = 0;
    logic [1:0] wr_sel = 0;
    logic [EXT_W-1:0] wr_addr = 0;
    logic [REC_W-1:0] wr_data = 0;

    always #2.5 clk = ~clk;

    vnu_lut_update u0 (.clk(clk), .rst_n(rst_n), .start(start), .iter(iter), .ch_sym(ch_sym),
        .c2v_sym(c2v_sym), .slot_en(slot_en), .out_valid(out_valid), .v2c_sym(v2c_sym),
        .hard_bit(hard_bit), .idle(idle), .wr_en(wr_en), .wr_iter(wr_iter), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data));

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Reference model state
    int m_ch [N_ITER][NSYM];
    int m_cv [N_ITER][NSYM];
    int m_q  [N_ITER][NQ];
    bit mid_v = 0, out_v = 0;
    int mid_sym [MAX_DEG], out_sym [MAX_DEG];
    int mid_hard = 0, out_hard = 0;

    function automatic int sx(int v);
        int t = v & 31;
        return (t >= 16) ? t - 32 : t;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model: advance delay line and apply accepted writes on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mid_v = 0; out_v = 0;
            for (int t = 0; t < N_ITER; t++) begin
                for (int s = 0; s < NSYM; s++) begin m_ch[t][s] = 0; m_cv[t][s] = 0; end
                for (int a = 0; a < NQ; a++) m_q[t][a] = 0;
            end
        end else begin
            bit wok;
            wok = wr_en && !start && !mid_v;
            out_v = mid_v; out_hard = mid_hard;
            for (int g = 0; g < MAX_DEG; g++) out_sym[g] = mid_sym[g];
            mid_v = start;
            if (start) begin
                int tot, own [MAX_DEG];
                tot = m_ch[iter][ch_sym];
                for (int g = 0; g < MAX_DEG; g++) begin
                    own[g] = slot_en[g] ? m_cv[iter][c2v_sym[g*SYM_W +: SYM_W]] : 0;
                    tot += own[g];
                end
                mid_hard = (tot < 0) ? 1 : 0;
                for (int g = 0; g < MAX_DEG; g++)
                    mid_sym[g] = slot_en[g] ? m_q[iter][(tot - own[g]) & (NQ - 1)] : 0;
            end
            if (wok) begin
                if (wr_sel == 0) m_ch[wr_iter][wr_addr % NSYM] = sx(wr_data);
                else if (wr_sel == 1) m_cv[wr_iter][wr_addr % NSYM] = sx(wr_data);
                else if (wr_sel == 2) m_q[wr_iter][wr_addr] = wr_data & (NSYM - 1);
            end
        end
    end

    // Per-cycle comparison between edges
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 out_valid", out_valid, out_v);
            chk("R9 idle", idle, !mid_v);
            if (out_v) begin
                chk("R5 hard_bit", hard_bit, out_hard);
                for (int g = 0; g < MAX_DEG; g++)
                    chk("R4 v2c_sym", v2c_sym[g*SYM_W +: SYM_W], out_sym[g]);
            end
        end
    end

    task automatic wr(int it, int sel, int addr, int data);
        wr_en = 1; wr_iter = it[IT_W-1:0]; wr_sel = sel[1:0];
        wr_addr = addr[EXT_W-1:0]; wr_data = data[REC_W-1:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic issue(int it, int ch, int cv, int en);
        start = 1; iter = it[IT_W-1:0]; ch_sym = ch[SYM_W-1:0];
        c2v_sym = cv[MAX_DEG*SYM_W-1:0]; slot_en = en[MAX_DEG-1:0];
        @(negedge clk);
    endtask

    task automatic quiet(int n);
        start = 0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seed = 12345;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 idle", idle, 1);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after", idle, 1);

        // R7: load every table
        for (int t = 0; t < N_ITER; t++) begin
            for (int s = 0; s < NSYM; s++) begin
                wr(t, 0, s, s * 3 + t * 5 + 1);
                wr(t, 1, s, s * 7 + t * 3 + 20);
            end
            for (int a = 0; a < NQ; a++) wr(t, 2, a, a * 5 + t * 3 + 1);
        end
        // R7: select 3 stores nothing
        wr(0, 3, 2, 9);

        // R3 R4 R6: pseudo-random ops, back-to-back and spaced
        for (int n = 0; n < 300; n++) begin
            seed = seed * 1103515245 + 12345;
            issue((seed >>> 8) & 3, (seed >>> 12) & 7, (seed >>> 4) & 4095, (seed >>> 18) & 15);
            if (((seed >>> 24) & 3) == 0) quiet(1);
        end
        quiet(3);

        // R10: most negative totals
        wr(2, 0, 7, 16);
        wr(2, 1, 7, 16);
        start = 1; iter = 2; ch_sym = 7; c2v_sym = {MAX_DEG{3'd7}}; slot_en = 4'hF;
        @(negedge clk); start = 0;
        @(negedge clk);
        chk("R10 hard at -80", hard_bit, 1);
        chk("R10 slot0 at -64", v2c_sym[2:0], (64 * 5 + 2 * 3 + 1) & 7);
        quiet(2);

        // R5: zero total decodes as 0
        wr(3, 0, 0, 0);
        start = 1; iter = 3; ch_sym = 0; c2v_sym = 0; slot_en = 0;
        @(negedge clk); start = 0;
        @(negedge clk);
        chk("R5 zero total", hard_bit, 0);
        chk("R6 masked slot", v2c_sym, 0);
        quiet(2);

        // R8: writes alongside start or while busy are dropped
        wr(1, 0, 3, 15);
        wr_en = 1; wr_iter = 1; wr_sel = 0; wr_addr = 3; wr_data = 5'd16;
        start = 1; iter = 0; ch_sym = 0; slot_en = 0;
        @(negedge clk); start = 0;
        chk("R8 busy", idle, 0);
        @(negedge clk); wr_en = 0;
        quiet(2);
        start = 1; iter = 1; ch_sym = 3; c2v_sym = 0; slot_en = 0;
        @(negedge clk); start = 0;
        @(negedge clk);
        chk("R8 entry unchanged", hard_bit, 0);
        chk("R2 strobe", out_valid, 1);
        quiet(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule